// File: doc/BRIEF.md
# Watchdog Refresh Unlock Guard

This block stands in front of a watchdog's refresh register. Software may not refresh the watchdog with a single store. It must first write a 16-bit unlock word, and the block compares that word with an expected value. The expected value depends on a 2-bit method selector. It can be the configured password, that password rotated left by one bit, a fixed constant, or a rolling value in which each accepted unlock word becomes the basis for the next one. A correct unlock opens a gate for a programmable number of bus cycles. While the gate is open, writing the 32-bit refresh key produces a one-cycle refresh strobe toward the watchdog counter, and the gate then closes again.

Misuse is recorded in two sticky event flags. A mismatched unlock word sets the unlock-fail flag. A refresh write that carries the wrong key, or that arrives while the gate is closed, sets the refresh-violation flag. Software clears a flag by writing a one to its bit in the status location. When the lock-enable configuration bit is low, no unlock is required and the refresh key alone is enough.

Top module: `wdt_refresh_guard`

## Requirements
- R1: After reset the gate is closed (`gate_open` = 0), both event flags are 0 and `refresh_pulse` is 0.
- R2: With method 0, an unlock write (address 0) whose data[15:0] equals `cfg_password` is accepted and opens the gate.
- R3: With method 1, the accepted unlock word is `cfg_password` rotated left by one bit, {pw[14:0], pw[15]}.
- R4: With method 2, the accepted unlock word is the constant 16'h55AA, whatever the password is. Data bits [31:16] of an unlock write are ignored.
- R5: With method 3, the accepted word is {L[14:0], L[15] ^ pw[0]}, where L is the chain value. L equals `cfg_password` from reset until the first accepted method-3 unlock. After that, L is the word last accepted under method 3, and it changes only on such an accepted unlock.
- R6: A write of 32'h5A45524F to the refresh address (1) while the gate is open raises `refresh_pulse` for exactly the following cycle and closes the gate at the same edge.
- R7: An unlock write whose data[15:0] does not match the expected word sets the unlock-fail flag (status bit 1) and closes the gate.
- R8: A refresh write with any other data, or one made while the gate is closed and locking is enabled, sets the refresh-violation flag (status bit 0). It gives no pulse and closes the gate.
- R9: With `cfg_lock_en` = 0, the refresh key is accepted without any unlock.
- R10: After an accepted unlock, the gate stays open for exactly `cfg_open_cycles` clock cycles, and then closes by itself. A value of 0 gives a gate that never opens.
- R11: The event flags are sticky. A write to the status address (2) clears unlock-fail where data bit 1 is 1 and clears refresh-violation where data bit 0 is 1. Zero bits leave their flag unchanged.
- R12: A write to any other address changes no flag and gives no pulse. Apart from the normal countdown, it does not change the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Write address (0 unlock, 1 refresh, 2 status) |
| wr_data | input | 32 | Write data |
| cfg_password | input | PW_W (16) | Configured unlock password |
| cfg_method | input | 2 | Unlock method selector (0..3) |
| cfg_lock_en | input | 1 | 1: refresh requires a prior unlock |
| cfg_open_cycles | input | CNT_W (16) | Gate open duration in cycles |
| refresh_pulse | output | 1 | One-cycle strobe to the watchdog counter |
| gate_open | output | 1 | Refresh gate currently open |
| evt_unlock_fail | output | 1 | Sticky unlock-fail event |
| evt_refresh_viol | output | 1 | Sticky refresh-violation event |

## Verification
The hardest state to reach from the ports is the method-3 chain after several links. There, the expected word depends on every earlier accepted unlock and on whether the chain has been seeded since reset. Before each step, the stimulus asks the bench's reference model for the word it currently expects. It also changes the password between links, so that an implementation that recomputed from the password, or that failed to hold the chain value, would miscompare. A wrong word is sent in the middle of the chain to show that a failed unlock leaves the chain value unchanged.

// File: rtl/wdg_refresh_pkg.sv
package wdg_refresh_pkg;
  typedef enum logic [1:0] {
    M_PLAIN  = 2'd0,
    M_ROTATE = 2'd1,
    M_FIXED  = 2'd2,
    M_CHAIN  = 2'd3
  } unlock_mode_e;

  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] REFRESH_KEY = 32'h5A45524F;
endpackage

// File: rtl/unlock_code_gen.sv
module unlock_code_gen
  import wdg_refresh_pkg::*;
#(
  parameter int unsigned PW_W = 16,
  parameter logic [PW_W-1:0] FIXED_KEY = 16'h55AA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW_W-1:0] cfg_pw,
  input  unlock_mode_e    mode,
  input  logic            commit,
  output logic [PW_W-1:0] expect_word
);
  logic [PW_W-1:0] last_q, last_d;
  logic            seeded_q, seeded_d;
  logic [PW_W-1:0] base;

  assign base = seeded_q ? last_q : cfg_pw;

  always_comb begin
    unique case (mode)
      M_PLAIN:  expect_word = cfg_pw;
      M_ROTATE: expect_word = {cfg_pw[PW_W-2:0], cfg_pw[PW_W-1]};
      M_FIXED:  expect_word = FIXED_KEY;
      default:  expect_word = {base[PW_W-2:0], base[PW_W-1] ^ cfg_pw[0]};
    endcase
  end

  always_comb begin
    last_d   = last_q;
    seeded_d = seeded_q;
    if (commit) begin
      last_d   = expect_word;
      seeded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      seeded_q <= 1'b0;
    end else begin
      last_q   <= last_d;
      seeded_q <= seeded_d;
    end
  end

  // R5: the chain value holds unless an accepted chained unlock occurs
  a_r5_chain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && seeded_q) |=> $stable(last_q));
endmodule

// File: rtl/open_window.sv
module open_window #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             close,
  output logic             open
);
  logic [CNT_W-1:0] remain_q, remain_d;

  always_comb begin
    remain_d = remain_q;
    if (load)                remain_d = load_val;
    else if (close)          remain_d = '0;
    else if (remain_q != '0) remain_d = remain_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else        remain_q <= remain_d;
  end

  assign open = (remain_q != '0);

  // R10: an open gate counts down by one each idle cycle
  a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !load && !close) |=> (remain_q == $past(remain_q) - 1'b1));
  // R10: a closed gate stays closed without a load
  a_r10_stay_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && !load) |=> !open);
endmodule

// File: rtl/event_flags.sv
module event_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_fail,
  input  logic       set_viol,
  input  logic [1:0] clr,
  output logic       fail_flag,
  output logic       viol_flag
);
  logic fail_q, fail_d, viol_q, viol_d;

  always_comb begin
    fail_d = set_fail | (fail_q & ~clr[1]);
    viol_d = set_viol | (viol_q & ~clr[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      fail_q <= fail_d;
      viol_q <= viol_d;
    end
  end

  assign fail_flag = fail_q;
  assign viol_flag = viol_q;

  // R11: flags stay set until cleared by a one in their bit
  a_r11_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr[1]) |=> fail_q);
  a_r11_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !clr[0]) |=> viol_q);
endmodule

// File: rtl/wdt_refresh_guard.sv
module wdt_refresh_guard
  import wdg_refresh_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned PW_W         = 16,
  parameter int unsigned CNT_W        = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR  = 4'd0,
  parameter logic [ADDR_W-1:0] REFRESH_ADDR = 4'd1,
  parameter logic [ADDR_W-1:0] STATUS_ADDR  = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [PW_W-1:0]   cfg_password,
  input  logic [1:0]        cfg_method,
  input  logic              cfg_lock_en,
  input  logic [CNT_W-1:0]  cfg_open_cycles,
  output logic              refresh_pulse,
  output logic              gate_open,
  output logic              evt_unlock_fail,
  output logic              evt_refresh_viol
);
  logic            hit_unlock, hit_refresh, hit_status;
  logic [PW_W-1:0] expect_word;
  logic            unlock_ok, unlock_bad, ref_ok, ref_bad;
  logic            key_match, may_refresh;
  logic [1:0]      clr_bits;
  logic            pulse_q, pulse_d;
  unlock_mode_e    mode;

  assign mode        = unlock_mode_e'(cfg_method);
  assign hit_unlock  = wr_en && (wr_addr == UNLOCK_ADDR);
  assign hit_refresh = wr_en && (wr_addr == REFRESH_ADDR);
  assign hit_status  = wr_en && (wr_addr == STATUS_ADDR);

  assign unlock_ok   = hit_unlock && (wr_data[PW_W-1:0] == expect_word);
  assign unlock_bad  = hit_unlock && !unlock_ok;
  assign key_match   = (wr_data == REFRESH_KEY);
  assign may_refresh = gate_open || !cfg_lock_en;
  assign ref_ok      = hit_refresh && key_match && may_refresh;
  assign ref_bad     = hit_refresh && !(key_match && may_refresh);
  assign clr_bits    = hit_status ? wr_data[1:0] : 2'b00;

  unlock_code_gen #(.PW_W(PW_W)) u_code (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_pw      (cfg_password),
    .mode        (mode),
    .commit      (unlock_ok && (mode == M_CHAIN)),
    .expect_word (expect_word)
  );

  open_window #(.CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (unlock_ok),
    .load_val (cfg_open_cycles),
    .close    (unlock_bad || ref_ok || ref_bad),
    .open     (gate_open)
  );

  event_flags u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_fail  (unlock_bad),
    .set_viol  (ref_bad),
    .clr       (clr_bits),
    .fail_flag (evt_unlock_fail),
    .viol_flag (evt_refresh_viol)
  );

  always_comb pulse_d = ref_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign refresh_pulse = pulse_q;

  // R6: an accepted refresh leaves the gate closed
  a_r6_pulse_closes: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |-> !gate_open);
  // R8: under locking, a pulse requires the gate to have been open
  a_r8_locked_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_pulse && $past(cfg_lock_en)) |-> $past(gate_open));
  // R12: foreign addresses leave flags alone and produce no pulse
  a_r12_foreign_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_unlock && !hit_refresh && !hit_status) |=>
      ($stable(evt_unlock_fail) && $stable(evt_refresh_viol) && !refresh_pulse));
endmodule

// File: tb/wdt_refresh_guard_bench.sv
module wdt_refresh_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] cfg_password = 16'hED09;
  logic [1:0]  cfg_method = 2'd0;
  logic        cfg_lock_en = 1'b1;
  logic [15:0] cfg_open_cycles = 16'd8;
  logic        refresh_pulse, gate_open, evt_unlock_fail, evt_refresh_viol;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  int          m_remain = 0;
  logic [15:0] m_last = '0;
  bit          m_seeded = 0;
  bit          m_uf = 0, m_rv = 0, m_pulse = 0;

  always #2.5 clk = ~clk;

  wdt_refresh_guard u_wdt_refresh_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_password(cfg_password), .cfg_method(cfg_method), .cfg_lock_en(cfg_lock_en),
    .cfg_open_cycles(cfg_open_cycles), .refresh_pulse(refresh_pulse),
    .gate_open(gate_open), .evt_unlock_fail(evt_unlock_fail),
    .evt_refresh_viol(evt_refresh_viol)
  );

  function automatic logic [15:0] m_expect();
    logic [15:0] b;
    b = m_seeded ? m_last : cfg_password;
    case (cfg_method)
      2'd0: return cfg_password;
      2'd1: return 16'((cfg_password << 1) | (cfg_password >> 15));
      2'd2: return 16'h55AA;
      default: return 16'((b << 1) | ((b >> 15) ^ (cfg_password & 16'h1)));
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_remain = 0; m_last = '0; m_seeded = 0; m_uf = 0; m_rv = 0; m_pulse = 0;
    end else begin
      int nrem;
      bit npulse;
      logic [15:0] e;
      npulse = 0;
      nrem = (m_remain > 0) ? m_remain - 1 : 0;
      e = m_expect();
      if (wr_en && wr_addr == 4'd0) begin
        if (wr_data[15:0] == e) begin
          nrem = int'(cfg_open_cycles);
          if (cfg_method == 2'd3) begin m_last = e; m_seeded = 1; end
        end else begin
          m_uf = 1; nrem = 0;
        end
      end else if (wr_en && wr_addr == 4'd1) begin
        if (wr_data == 32'h5A45524F && (m_remain > 0 || !cfg_lock_en)) npulse = 1;
        else m_rv = 1;
        nrem = 0;
      end else if (wr_en && wr_addr == 4'd2) begin
        if (wr_data[1]) m_uf = 0;
        if (wr_data[0]) m_rv = 0;
      end
      m_remain = nrem;
      m_pulse = npulse;
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input bit en, input logic [3:0] a, input logic [31:0] d);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    vectors++;
    check(tag, "gate_open", gate_open, m_remain > 0);
    check(tag, "refresh_pulse", refresh_pulse, m_pulse);
    check(tag, "evt_unlock_fail", evt_unlock_fail, m_uf);
    check(tag, "evt_refresh_viol", evt_refresh_viol, m_rv);
    wr_en = 1'b0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 4'd0, 32'h0);
  endtask

  localparam logic [31:0] KEY = 32'h5A45524F;

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle("R1", 1);
    rst_n = 1'b1;
    idle("R1", 2);

    // R2 plain password, then refresh R6
    cyc("R2", 1, 4'd0, {16'hFFFF, m_expect()});
    idle("R2", 2);
    cyc("R6", 1, 4'd1, KEY);
    idle("R6", 2);
    // R8 refresh while closed
    cyc("R8", 1, 4'd1, KEY);
    // R11 zero write leaves, one clears
    cyc("R11", 1, 4'd2, 32'h0);
    cyc("R11", 1, 4'd2, 32'h1);
    // R3 rotated: the plain word must fail (R7), the rotated one open
    cfg_method = 2'd1;
    cyc("R7", 1, 4'd0, 32'h0000ED09);
    cyc("R3", 1, 4'd0, {16'h0, m_expect()});
    cyc("R8", 1, 4'd1, KEY ^ 32'h1);
    cyc("R11", 1, 4'd2, 32'h2);
    cyc("R11", 1, 4'd2, 32'h1);
    // R4 fixed key, upper bits junk
    cfg_method = 2'd2;
    cfg_password = 16'h1234;
    cyc("R4", 1, 4'd0, 32'hDEAD55AA);
    cyc("R6", 1, 4'd1, KEY);
    idle("R6", 1);
    // R5 chain, seeded by password, password changed between links
    cfg_method = 2'd3;
    cfg_password = 16'hED09;
    cyc("R5", 1, 4'd0, {16'h0, m_expect()});
    cfg_password = 16'h0001;
    cyc("R5", 1, 4'd0, {16'h0, m_expect()});
    cyc("R7", 1, 4'd0, {16'h0, ~m_expect()});
    cfg_password = 16'h8000;
    cyc("R5", 1, 4'd0, {16'h0, m_expect()});
    cyc("R5", 1, 4'd0, 32'h0000ED09);
    cyc("R5", 1, 4'd0, {16'h0, m_expect()});
    cyc("R6", 1, 4'd1, KEY);
    cyc("R11", 1, 4'd2, 32'h3);
    // R10 window expiry and zero period
    cfg_method = 2'd0;
    cfg_open_cycles = 16'd3;
    cyc("R10", 1, 4'd0, {16'h0, m_expect()});
    idle("R10", 4);
    cyc("R10", 1, 4'd1, KEY);
    cfg_open_cycles = 16'd3;
    cyc("R10", 1, 4'd0, {16'h0, m_expect()});
    idle("R10", 2);
    cyc("R10", 1, 4'd1, KEY);
    cfg_open_cycles = 16'd0;
    cyc("R10", 1, 4'd0, {16'h0, m_expect()});
    cyc("R10", 1, 4'd1, KEY);
    cyc("R11", 1, 4'd2, 32'h3);
    // R9 lock disabled
    cfg_lock_en = 1'b0;
    cyc("R9", 1, 4'd1, KEY);
    cyc("R9", 1, 4'd1, KEY);
    cyc("R9", 1, 4'd1, 32'h0);
    cfg_lock_en = 1'b1;
    // R12 foreign addresses
    cfg_open_cycles = 16'd6;
    cyc("R12", 1, 4'd0, {16'h0, m_expect()});
    cyc("R12", 1, 4'd5, KEY);
    cyc("R12", 1, 4'd15, 32'hFFFFFFFF);
    cyc("R12", 1, 4'd1, KEY);
    cyc("R11", 1, 4'd2, 32'h3);
    idle("R1", 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule